// File: doc/BRIEF.md
# Tape Controller Command and Status Sequencer

This block is the command front end of a controller that serves four tape drives. Software writes an 8-bit command byte aimed at one drive. The block checks the byte against the set of supported functions and against the drive's attach and write-protect state. If the command is accepted, it emits a one-cycle start strobe towards the drive model. When the drive model reports that motion has finished, the block walks through a timed completion sequence. A file mark first raises end-of-file. One record delay later, busy drops and end-of-motion rises. After a second record delay, no-motion rises. Each of these steps can produce an interrupt.

The status byte mixes flags that the controller shares across drives (error, end of file, busy, end of motion) with flags kept for each drive (end of tape, no motion). It is read for the drive picked by `statusSel`. The drive model is represented by a `doneValid` pulse carrying result flags. Byte-level data movement is not part of this block.

The upper two bits of every command byte also update the interrupt arm bit of the addressed drive, even when the function itself is ignored. Code 01 arms the drive. Code 10 disarms it. Any other code leaves the arm bit alone.

Top module: `tape_cmd_seq`

## Requirements
- R1: The function is `cmdByte[5:0]`. Only 0x11 (backspace record), 0x13 (space file reverse), 0x20 (clear), 0x21 (read), 0x22 (write), 0x23 (space file forward), 0x30 (write file mark) and 0x38 (rewind) are acted on. Every other code produces no start strobe and changes no status.
- R2: A command produces no start in either of these cases: the addressed drive is not attached, or the function is write (0x22) or write file mark (0x30) and the drive is write protected.
- R3: A command to a drive whose operation is still running, before the drive has reached its stop stages, is ignored. A command to a drive that is in either stop stage is accepted.
- R4: On a start, end of tape and no motion are cleared for that drive, and error, end of file and end of motion are cleared for the controller. Busy becomes 0 for write and rewind, and 1 for every other function.
- R5: Accepting a command cancels any operation still in progress on another drive, unless that operation is a rewind. A done pulse for a cancelled drive has no effect.
- R6: Reset and the clear command (0x20) both set busy, clear error, end of file and end of motion, disarm every drive's interrupt, stop every drive and set no motion on every drive. Clear keeps each drive's end of tape. Reset clears it.
- R7: A done pulse for a write file mark, or a done pulse carrying the file-mark flag, sets end of file at once while busy stays 1. It also pulses that drive's interrupt in the following cycle.
- R8: `recDelay` cycles after the done edge (a value of 0 counts as 1), busy clears, end of motion sets and the drive's interrupt pulses.
- R9: `recDelay` cycles after end of motion, the drive's no motion sets, its interrupt pulses and the drive becomes idle.
- R10: A rewind completes on its done pulse. It sets no motion and end of tape for the drive, clears busy without setting end of motion, and pulses the interrupt once.
- R11: Status bits are error 0x80, end of file 0x40, end of tape 0x20, no motion 0x10, busy 0x08, end of motion 0x04, exception 0x02 and unavailable 0x01. Exception is set whenever error, end of file or no motion is shown. For an unattached drive, unavailable is set and end of tape and no motion read as 0.
- R12: Each interrupt is a one-cycle pulse on `irq[drive]`. It occurs only while that drive is armed. `cmdByte[7:6]` = 01 arms the addressed drive and 10 disarms it.
- R13: A done pulse with its error flag sets error. A done pulse with its end-of-tape flag sets that drive's end of tape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command byte write strobe |
| cmdDrive | input | 2 | Drive addressed by the command |
| cmdByte | input | 8 | Arm control [7:6] and function [5:0] |
| attached | input | 4 | Per-drive attached flag |
| wrProt | input | 4 | Per-drive write protect flag |
| recDelay | input | 8 | Record delay in cycles for each stop stage |
| doneValid | input | 1 | Drive model reports end of motion |
| doneDrive | input | 2 | Drive reporting done |
| doneFileMark | input | 1 | A file mark was met |
| doneError | input | 1 | The operation failed |
| doneEndTape | input | 1 | The end-of-tape marker was passed |
| statusSel | input | 2 | Drive whose status is shown |
| statusByte | output | 8 | Combined status for the selected drive |
| irq | output | 4 | Per-drive interrupt pulses |
| startValid | output | 1 | One-cycle start strobe to the drive model |
| startDrive | output | 2 | Drive being started |
| startFunc | output | 6 | Function being started |

## Verification
The bench builds the block with its defaults: four drives and an 8-bit delay field. It drives `recDelay` at 3, so each stop stage lasts several cycles. That leaves room to sample the cycles between the staged interrupts and to issue a new command while a drive is in a stop stage. With four drives, a rewind can run on one drive while commands on two others exercise cancellation and the ignored done pulse. Random command bytes are checked against an acceptance function that uses random attach and protect masks. Directed runs step through every completion path.

// File: rtl/tape_seq_pkg.sv
package tape_seq_pkg;
  localparam logic [5:0] FN_BACKSP  = 6'h11;
  localparam logic [5:0] FN_SKIPREV = 6'h13;
  localparam logic [5:0] FN_CLEAR   = 6'h20;
  localparam logic [5:0] FN_READ    = 6'h21;
  localparam logic [5:0] FN_WRITE   = 6'h22;
  localparam logic [5:0] FN_SKIPFWD = 6'h23;
  localparam logic [5:0] FN_MARK    = 6'h30;
  localparam logic [5:0] FN_REWIND  = 6'h38;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_STOP1, ST_STOP2} unit_st_e;

  // strobes from control to status datapath
  typedef struct packed {
    logic clrAll;
    logic start;
    logic startQuiet;
    logic setErr;
    logic setEof;
    logic endBusy;
    logic setEom;
  } stb_t;

  function automatic logic fnKnown(logic [5:0] f);
    case (f)
      FN_BACKSP, FN_SKIPREV, FN_CLEAR, FN_READ, FN_WRITE,
      FN_SKIPFWD, FN_MARK, FN_REWIND: fnKnown = 1'b1;
      default: fnKnown = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tape_seq_ctrl.sv
module tape_seq_ctrl
  import tape_seq_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int DELAY_W = 8,
  parameter int SEL_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmdValid,
  input  logic [SEL_W-1:0] cmdDrive,
  input  logic [7:0] cmdByte,
  input  logic [NUM_DRIVES-1:0] attached,
  input  logic [NUM_DRIVES-1:0] wrProt,
  input  logic [DELAY_W-1:0] recDelay,
  input  logic doneValid,
  input  logic [SEL_W-1:0] doneDrive,
  input  logic doneFileMark,
  input  logic doneError,
  input  logic doneEndTape,
  output stb_t stb,
  output logic [NUM_DRIVES-1:0] unitClr,
  output logic [NUM_DRIVES-1:0] unitSetNmtn,
  output logic [NUM_DRIVES-1:0] unitSetEot,
  output logic [NUM_DRIVES-1:0] irq,
  output logic startValid,
  output logic [SEL_W-1:0] startDrive,
  output logic [5:0] startFunc
);
  logic [5:0] func;
  logic isClear, isWrite, accept;
  logic [DELAY_W-1:0] delayLoad;
  logic [NUM_DRIVES-1:0] runVec, activeNR, rewFin, opDone, markHit;
  logic [NUM_DRIVES-1:0] eomFire, nmtnFire, errHit, irqNext, armReg;

  assign func      = cmdByte[5:0];
  assign isClear   = cmdValid && (func == FN_CLEAR);
  assign isWrite   = (func == FN_WRITE) || (func == FN_MARK);
  assign delayLoad = (recDelay == '0) ? DELAY_W'(1) : recDelay;
  assign accept    = cmdValid && fnKnown(func) && !isClear &&
                     attached[cmdDrive] && !(isWrite && wrProt[cmdDrive]) &&
                     !runVec[cmdDrive];

  for (genvar u = 0; u < NUM_DRIVES; u++) begin : g_unit
    unit_st_e st;
    logic [5:0] fn;
    logic [DELAY_W-1:0] cnt;
    logic startHere, cancelHere, hold, doneAct, isRew, tick;

    assign isRew      = (fn == FN_REWIND);
    assign startHere  = accept && (cmdDrive == SEL_W'(u));
    assign cancelHere = accept && !startHere && (st != ST_IDLE) && !isRew;
    assign hold       = isClear || startHere || cancelHere;
    assign doneAct    = doneValid && (doneDrive == SEL_W'(u)) && (st == ST_RUN) && !hold;
    assign tick       = ((st == ST_STOP1) || (st == ST_STOP2)) && (cnt <= DELAY_W'(1)) && !hold;

    assign runVec[u]   = (st == ST_RUN);
    assign activeNR[u] = (st != ST_IDLE) && !isRew;
    assign rewFin[u]   = doneAct && isRew;
    assign opDone[u]   = doneAct && !isRew;
    assign markHit[u]  = opDone[u] && (doneFileMark || (fn == FN_MARK));
    assign errHit[u]   = opDone[u] && doneError;
    assign eomFire[u]  = tick && (st == ST_STOP1);
    assign nmtnFire[u] = tick && (st == ST_STOP2);

    assign unitClr[u]     = startHere;
    assign unitSetNmtn[u] = rewFin[u] || nmtnFire[u];
    assign unitSetEot[u]  = rewFin[u] || (opDone[u] && doneEndTape);
    assign irqNext[u]     = armReg[u] && (rewFin[u] || markHit[u] || eomFire[u] || nmtnFire[u]);

    always_ff @(posedge clk) begin
      if (!rst_n || isClear) begin
        st  <= ST_IDLE;
        fn  <= '0;
        cnt <= '0;
      end else if (startHere) begin
        st  <= ST_RUN;
        fn  <= func;
        cnt <= '0;
      end else if (cancelHere || rewFin[u]) begin
        st <= ST_IDLE;
      end else if (opDone[u]) begin
        st  <= ST_STOP1;
        cnt <= delayLoad;
      end else if (tick) begin
        st  <= (st == ST_STOP1) ? ST_STOP2 : ST_IDLE;
        cnt <= delayLoad;
      end else if ((st == ST_STOP1) || (st == ST_STOP2)) begin
        cnt <= cnt - DELAY_W'(1);
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || isClear) armReg[u] <= 1'b0;
      else if (cmdValid && (cmdDrive == SEL_W'(u))) begin
        if (cmdByte[7:6] == 2'b01) armReg[u] <= 1'b1;
        else if (cmdByte[7:6] == 2'b10) armReg[u] <= 1'b0;
      end
    end
  end

  always_comb begin
    stb.clrAll     = isClear;
    stb.start      = accept;
    stb.startQuiet = (func == FN_WRITE) || (func == FN_REWIND);
    stb.setErr     = |errHit;
    stb.setEof     = |markHit;
    stb.endBusy    = |(rewFin | eomFire);
    stb.setEom     = |eomFire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq        <= '0;
      startValid <= 1'b0;
      startDrive <= '0;
      startFunc  <= '0;
    end else begin
      irq        <= irqNext;
      startValid <= accept;
      startDrive <= cmdDrive;
      startFunc  <= func;
    end
  end

  p_unattached_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && !attached[cmdDrive] |=> !startValid);
  p_running_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && runVec[cmdDrive] |=> !startValid);
  p_single_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(activeNR));
  p_irq_armed_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~$past(armReg)) == '0);
endmodule

// File: rtl/tape_seq_dp.sv
module tape_seq_dp
  import tape_seq_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int SEL_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  stb_t stb,
  input  logic [NUM_DRIVES-1:0] unitClr,
  input  logic [NUM_DRIVES-1:0] unitSetNmtn,
  input  logic [NUM_DRIVES-1:0] unitSetEot,
  input  logic [NUM_DRIVES-1:0] attached,
  input  logic [SEL_W-1:0] statusSel,
  output logic [7:0] statusByte
);
  logic errR, eofR, busyR, eomR;
  logic [NUM_DRIVES-1:0] eotR, nmtnR;
  logic selAtt, selEot, selNmtn;

  always_ff @(posedge clk) begin
    if (!rst_n || stb.clrAll) begin
      busyR <= 1'b1;
      errR  <= 1'b0;
      eofR  <= 1'b0;
      eomR  <= 1'b0;
    end else if (stb.start) begin
      busyR <= !stb.startQuiet;
      errR  <= 1'b0;
      eofR  <= 1'b0;
      eomR  <= 1'b0;
    end else begin
      if (stb.setErr)  errR  <= 1'b1;
      if (stb.setEof)  eofR  <= 1'b1;
      if (stb.endBusy) busyR <= 1'b0;
      if (stb.setEom)  eomR  <= 1'b1;
    end
  end

  for (genvar u = 0; u < NUM_DRIVES; u++) begin : g_flags
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        eotR[u]  <= 1'b0;
        nmtnR[u] <= 1'b1;
      end else if (stb.clrAll) begin
        nmtnR[u] <= 1'b1;
      end else if (unitClr[u]) begin
        eotR[u]  <= 1'b0;
        nmtnR[u] <= 1'b0;
      end else begin
        if (unitSetEot[u])  eotR[u]  <= 1'b1;
        if (unitSetNmtn[u]) nmtnR[u] <= 1'b1;
      end
    end
  end

  assign selAtt  = attached[statusSel];
  assign selEot  = selAtt && eotR[statusSel];
  assign selNmtn = selAtt && nmtnR[statusSel];
  assign statusByte = {errR, eofR, selEot, selNmtn, busyR, eomR,
                       errR || eofR || selNmtn, !selAtt};

  p_clear_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clrAll |=> busyR && (&nmtnR) && !errR && !eomR);
  p_eom_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eomR) |-> !busyR);
endmodule

// File: rtl/tape_cmd_seq.sv
module tape_cmd_seq
  import tape_seq_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int DELAY_W = 8,
  localparam int SEL_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmdValid,
  input  logic [SEL_W-1:0] cmdDrive,
  input  logic [7:0] cmdByte,
  input  logic [NUM_DRIVES-1:0] attached,
  input  logic [NUM_DRIVES-1:0] wrProt,
  input  logic [DELAY_W-1:0] recDelay,
  input  logic doneValid,
  input  logic [SEL_W-1:0] doneDrive,
  input  logic doneFileMark,
  input  logic doneError,
  input  logic doneEndTape,
  input  logic [SEL_W-1:0] statusSel,
  output logic [7:0] statusByte,
  output logic [NUM_DRIVES-1:0] irq,
  output logic startValid,
  output logic [SEL_W-1:0] startDrive,
  output logic [5:0] startFunc
);
  stb_t stb;
  logic [NUM_DRIVES-1:0] unitClr, unitSetNmtn, unitSetEot;

  tape_seq_ctrl #(.NUM_DRIVES(NUM_DRIVES), .DELAY_W(DELAY_W), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdDrive(cmdDrive),
    .cmdByte(cmdByte), .attached(attached), .wrProt(wrProt), .recDelay(recDelay),
    .doneValid(doneValid), .doneDrive(doneDrive), .doneFileMark(doneFileMark),
    .doneError(doneError), .doneEndTape(doneEndTape), .stb(stb),
    .unitClr(unitClr), .unitSetNmtn(unitSetNmtn), .unitSetEot(unitSetEot),
    .irq(irq), .startValid(startValid), .startDrive(startDrive), .startFunc(startFunc));

  tape_seq_dp #(.NUM_DRIVES(NUM_DRIVES), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .unitClr(unitClr),
    .unitSetNmtn(unitSetNmtn), .unitSetEot(unitSetEot), .attached(attached),
    .statusSel(statusSel), .statusByte(statusByte));
endmodule

// File: tb/tape_cmd_seq_test.sv
module tape_cmd_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdDrive = '0;
  logic [7:0] cmdByte = '0;
  logic [3:0] attached = 4'hF;
  logic [3:0] wrProt = 4'h0;
  logic [7:0] recDelay = 8'd3;
  logic doneValid = 1'b0;
  logic [1:0] doneDrive = '0;
  logic doneFileMark = 1'b0, doneError = 1'b0, doneEndTape = 1'b0;
  logic [1:0] statusSel = '0;
  logic [7:0] statusByte;
  logic [3:0] irq;
  logic startValid;
  logic [1:0] startDrive;
  logic [5:0] startFunc;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tape_cmd_seq uut (.*);

  function automatic bit knownFn(logic [5:0] f);
    return f inside {6'h11, 6'h13, 6'h20, 6'h21, 6'h22, 6'h23, 6'h30, 6'h38};
  endfunction

  function automatic logic [7:0] expSt(bit er, bit ef, bit et, bit nm, bit bs, bit em, bit at);
    bit nmv = at && nm;
    return {er, ef, at && et, nmv, bs, em, er || ef || nmv, !at};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic getSt(int drv, output logic [7:0] v);
    statusSel = 2'(drv);
    #1 v = statusByte;
  endtask

  task automatic cmd(int drv, logic [7:0] b);
    cmdDrive = 2'(drv); cmdByte = b; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic done(int drv, bit fm, bit er, bit et);
    doneDrive = 2'(drv); doneFileMark = fm; doneError = er; doneEndTape = et;
    doneValid = 1'b1;
    @(negedge clk);
    doneValid = 1'b0; doneFileMark = 0; doneError = 0; doneEndTape = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [7:0] s;
    logic [3:0] irqSeen;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 R11: reset state
    getSt(0, s); chk("R6 reset status", s, expSt(0,0,0,1,1,0,1));
    chk("R6 irq idle", {4'h0, irq}, 8'h00);
    attached[3] = 1'b0;
    getSt(3, s); chk("R11 unavailable", s, expSt(0,0,0,1,1,0,0));
    attached[3] = 1'b1;

    // R7 R8 R9: write file mark, armed
    cmd(0, 8'h70);
    chk("R4 start strobe", {7'h0, startValid}, 8'h01);
    chk("R4 start func", {2'b0, startFunc}, 8'h30);
    getSt(0, s); chk("R4 mark start", s, expSt(0,0,0,0,1,0,1));
    done(0, 0, 0, 0);
    getSt(0, s); chk("R7 eof busy", s, expSt(0,1,0,0,1,0,1));
    chk("R7 irq", {4'h0, irq}, 8'h01);
    @(negedge clk); @(negedge clk);
    getSt(0, s); chk("R8 still busy", s, expSt(0,1,0,0,1,0,1));
    chk("R8 no irq yet", {4'h0, irq}, 8'h00);
    @(negedge clk);
    getSt(0, s); chk("R8 eom", s, expSt(0,1,0,0,0,1,1));
    chk("R8 irq", {4'h0, irq}, 8'h01);
    @(negedge clk); @(negedge clk);
    chk("R9 no irq yet", {4'h0, irq}, 8'h00);
    @(negedge clk);
    getSt(0, s); chk("R9 nmtn", s, expSt(0,1,0,1,0,1,1));
    chk("R9 irq", {4'h0, irq}, 8'h01);
    @(negedge clk);
    chk("R12 one cycle pulse", {4'h0, irq}, 8'h00);

    // R4 R13: write with error
    cmd(1, 8'h62);
    getSt(1, s); chk("R4 write start", s, expSt(0,0,0,0,0,0,1));
    done(1, 0, 1, 0);
    getSt(1, s); chk("R13 error", s, expSt(1,0,0,0,0,0,1));
    chk("R7 no eof irq", {4'h0, irq}, 8'h00);
    repeat (7) @(negedge clk);

    // R10: rewind
    cmd(2, 8'h78);
    getSt(2, s); chk("R4 rewind start", s, expSt(0,0,0,0,0,0,1));
    done(2, 0, 0, 0);
    getSt(2, s); chk("R10 rewind done", s, expSt(0,0,1,1,0,0,1));
    chk("R10 irq", {4'h0, irq}, 8'h04);
    irqSeen = '0;
    repeat (5) begin @(negedge clk); irqSeen |= irq; end
    getSt(2, s); chk("R10 no eom", s, expSt(0,0,1,1,0,0,1));
    chk("R10 single irq", {4'h0, irqSeen}, 8'h00);

    // R3: running drive ignores, stopping drive accepts
    cmd(3, 8'h61);
    chk("R3 first start", {7'h0, startValid}, 8'h01);
    cmd(3, 8'h21);
    chk("R3 busy ignored", {7'h0, startValid}, 8'h00);
    done(3, 0, 0, 0);
    cmd(3, 8'h21);
    chk("R3 stop stage accept", {7'h0, startValid}, 8'h01);
    cmd(0, 8'h20);

    // R5: cancel others, rewind survives
    cmd(2, 8'h78);
    cmd(0, 8'h61);
    cmd(1, 8'h51);
    done(0, 1, 0, 0);
    irqSeen = '0;
    repeat (8) begin @(negedge clk); irqSeen |= irq; end
    getSt(0, s); chk("R5 cancelled status", s, expSt(0,0,0,0,1,0,1));
    chk("R5 cancelled no irq", {7'h0, irqSeen[0]}, 8'h00);
    done(2, 0, 0, 0);
    chk("R5 rewind kept", {4'h0, irq}, 8'h04);

    // R6: clear command keeps eot, disarms
    cmd(0, 8'h60);
    chk("R6 clear no start", {7'h0, startValid}, 8'h00);
    getSt(2, s); chk("R6 clear eot kept", s, expSt(0,0,1,1,1,0,1));
    getSt(0, s); chk("R6 clear drive0", s, expSt(0,0,0,1,1,0,1));

    // R12: disarmed operation raises no interrupt
    cmd(0, 8'h30);
    done(0, 0, 0, 0);
    irqSeen = irq;
    repeat (7) begin @(negedge clk); irqSeen |= irq; end
    chk("R12 disarmed", {4'h0, irqSeen}, 8'h00);
    getSt(0, s); chk("R9 sequence without irq", s, expSt(0,1,0,1,0,1,1));

    // R13: end of tape
    cmd(0, 8'h21);
    done(0, 0, 0, 1);
    getSt(0, s); chk("R13 eot", s, expSt(0,0,1,0,1,0,1));
    repeat (7) @(negedge clk);

    // R2: write protect
    wrProt = 4'b0010;
    cmd(1, 8'h22); chk("R2 protected write", {7'h0, startValid}, 8'h00);
    cmd(1, 8'h30); chk("R2 protected mark", {7'h0, startValid}, 8'h00);
    cmd(1, 8'h21); chk("R2 protected read ok", {7'h0, startValid}, 8'h01);
    cmd(0, 8'h20);

    // R1 R2: random command bytes
    for (int i = 0; i < 60; i++) begin
      logic [5:0] f;
      int d;
      bit expect1;
      logic [5:0] codes [8] = '{6'h11, 6'h13, 6'h20, 6'h21, 6'h22, 6'h23, 6'h30, 6'h38};
      f = ($urandom % 2) ? codes[$urandom % 8] : 6'($urandom);
      d = int'($urandom % 4);
      attached = 4'($urandom) | 4'b0001;
      wrProt = 4'($urandom);
      expect1 = knownFn(f) && (f != 6'h20) && attached[d] &&
                !(((f == 6'h22) || (f == 6'h30)) && wrProt[d]);
      getSt(d, s);
      cmd(d, {2'($urandom), f});
      chk($sformatf("R1 R2 random f=%02h", f), {7'h0, startValid}, {7'h0, expect1});
      if (!expect1) begin
        logic [7:0] s2;
        getSt(d, s2);
        chk("R1 ignored no change", s2, s);
      end
      cmd(0, 8'h20);
    end

    finish();
  end
endmodule